// File: doc/BRIEF.md
# Page-to-Sprite-Memory Copy Engine

This block copies one 256-byte page of processor memory into the 256-byte sprite attribute store of the video unit. That store holds 64 sprite records of 4 bytes each. Software starts a copy with a single bus write to a trigger register. The byte it writes selects the source page. From the next cycle the engine holds the processor stalled and drives the memory read port and the sprite-store write port by itself. When the last byte has been written it gives the processor the bus back.

Each byte takes two cycles. In the first cycle the engine reads the byte. In the second it writes the returned byte into the sprite store. The source low byte and the destination index both count from 0 up to 255. A done pulse marks the end of the copy, and the stall is released one cycle after that pulse.

Top module: `page_dma`

## Requirements
- R1: After reset, `halt_o`, `mem_rd_o`, `oam_we_o` and `done_o` are all low.
- R2: A write with `cpu_wr_i` high and `cpu_addr_i` equal to 0x4014 (the `TRIG_ADDR` parameter), made while the engine is idle, raises `halt_o` in the next cycle. A write to any other address leaves `halt_o` and `mem_rd_o` low.
- R3: Every read drives `mem_addr_o` as {triggering write data in bits 15:8, byte index in bits 7:0}. The index starts at 0x00 on the first read and ends at 0xFF.
- R4: Each read cycle is followed directly by one write cycle. In that write cycle `oam_wdata_o` equals `mem_rdata_i`, which the memory returns one cycle after the read. Read, write and done are never asserted in the same cycle.
- R5: `oam_addr_o` is 0 on the first write and increases by one on each later write.
- R6: One transfer makes exactly 256 reads and 256 writes.
- R7: `done_o` is high for exactly one cycle, directly after the 256th write. `halt_o` and `done_o` are both low in the cycle after that.
- R8: A trigger write that arrives while `halt_o` is high is ignored. The source page stays the same and no second transfer follows.
- R9: `halt_o` stays high without a gap from the first read to the done cycle: 513 cycles per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | 16 | Processor write address |
| cpu_wdata_i | input | 8 | Processor write data; its value selects the source page |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after `mem_rd_o` |
| oam_we_o | output | 1 | Sprite store write enable |
| oam_addr_o | output | 8 | Sprite store write index |
| oam_wdata_o | output | 8 | Sprite store write data |
| halt_o | output | 1 | Stall request to the processor |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions check the cycle-by-cycle rules on every cycle:
- read and write alternate, and each write index matches the read that came before it;
- the index steps by one between bytes;
- done follows the write at index 0xFF, and halt falls only right after done;
- the source page holds steady while a transfer runs.

Some properties only show up across a whole copy, so the bench scenarios cover them:
- the total of 256 bytes and the 513-cycle stall length;
- the data values that arrive in the sprite store;
- triggers dropped when sent mid-transfer at random points;
- writes to other addresses that start nothing.

// File: rtl/page_dma_pkg.sv
package page_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } dma_state_e;
endpackage

// File: rtl/page_dma_trig.sv
module page_dma_trig #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              start_o
);
  // busy drops the request entirely; nothing is queued
  assign start_o = wr_i && (addr_i == TRIG_ADDR) && !busy_i;
endmodule

// File: rtl/page_dma_addr.sv
module page_dma_addr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      page_q <= page_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign page_o = page_q;
  assign idx_o  = idx_q;
  assign last_o = &idx_q;
endmodule

// File: rtl/page_dma_fsm.sv
module page_dma_fsm
  import page_dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_i,
  output dma_state_e state_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_i ? ST_DONE : ST_READ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_idle_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> state_q == ST_IDLE);
endmodule

// File: rtl/page_dma.sv
module page_dma
  import page_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  localparam int unsigned PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              oam_we_o,
  output logic [IDX_W-1:0]  oam_addr_o,
  output logic [DATA_W-1:0] oam_wdata_o,
  output logic              halt_o,
  output logic              done_o
);
  dma_state_e        state;
  logic              start, last;
  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;

  page_dma_trig #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_trig (
    .wr_i(cpu_wr_i), .addr_i(cpu_addr_i), .busy_i(halt_o), .start_o(start)
  );

  page_dma_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .page_i(cpu_wdata_i[PAGE_W-1:0]), .step_i(oam_we_o),
    .page_o(page), .idx_o(idx), .last_o(last)
  );

  page_dma_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .last_i(last), .state_o(state)
  );

  assign mem_rd_o    = (state == ST_READ);
  assign oam_we_o    = (state == ST_WRITE);
  assign done_o      = (state == ST_DONE);
  assign halt_o      = (state != ST_IDLE);
  assign mem_addr_o  = {page, idx};
  assign oam_addr_o  = idx;
  // read data returns one cycle after the read, i.e. in the write cycle
  assign oam_wdata_o = oam_we_o ? mem_rdata_i : '0;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !halt_o) |=> (halt_o && mem_rd_o));
  assert_first_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (mem_addr_o == {$past(cpu_wdata_i[PAGE_W-1:0]), {IDX_W{1'b0}}}));
  assert_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, oam_we_o, done_o}));
  assert_rd_then_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (oam_we_o && oam_addr_o == $past(mem_addr_o[IDX_W-1:0])));
  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oam_we_o && oam_addr_o != '1) |=>
      (mem_rd_o && mem_addr_o[IDX_W-1:0] == IDX_W'($past(oam_addr_o) + 1'b1)));
  assert_last_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oam_we_o && oam_addr_o == '1) |=> done_o);
  assert_done_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!halt_o && !done_o));
  assert_page_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !done_o) |=> $stable(mem_addr_o[ADDR_W-1:IDX_W]));
  assert_halt_contig_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> $past(done_o));
endmodule

// File: tb/page_dma_bench.sv
`timescale 1ns/1ps
module page_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_rd, oam_we, halt, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  oam_addr, oam_wdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rd_cnt, wr_cnt, halt_cnt, done_cnt;
  logic [7:0] cur_page = '0;
  logic [7:0] salt = '0;
  logic       last_rd = 1'b0;

  always #2 clk = ~clk;

  page_dma u_page_dma (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .oam_we_o(oam_we), .oam_addr_o(oam_addr),
    .oam_wdata_o(oam_wdata), .halt_o(halt), .done_o(done)
  );

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ salt ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and running monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        chk(mem_addr == {cur_page, rd_cnt[7:0]}, "R3 read address",
            int'(mem_addr), int'({cur_page, rd_cnt[7:0]}));
        rd_cnt++;
        mem_rdata <= exp_byte(mem_addr);
      end
      if (oam_we) begin
        chk(oam_addr == wr_cnt[7:0], "R5 write index", int'(oam_addr), wr_cnt);
        chk(oam_wdata == exp_byte({cur_page, oam_addr}), "R4 write data",
            int'(oam_wdata), int'(exp_byte({cur_page, oam_addr})));
        chk(last_rd, "R4 read before write", 0, 1);
        wr_cnt++;
      end
      if (halt) halt_cnt++;
      if (done) done_cnt++;
      last_rd <= mem_rd;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic run_dma(input logic [7:0] pg, input bit busy_trig);
    int guard = 0;
    rd_cnt = 0; wr_cnt = 0; halt_cnt = 0; done_cnt = 0;
    cur_page = pg;
    salt = 8'($urandom);
    bus_write(16'h4014, pg);
    chk(halt == 1'b1, "R2 halt after trigger", int'(halt), 1);
    chk(mem_rd && mem_addr == {pg, 8'h00}, "R3 first read", int'(mem_addr), int'({pg, 8'h00}));
    if (busy_trig) begin
      repeat (1 + ($urandom % 400)) @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = 16'h4014; cpu_wdata = ~pg;
      @(negedge clk);
      cpu_wr = 1'b0;
    end
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R7 done seen", int'(done), 1);
    chk(wr_cnt == 256, "R6 write count", wr_cnt, 256);
    chk(rd_cnt == 256, "R6 read count", rd_cnt, 256);
    @(negedge clk);
    chk(!halt && !done, "R7 release after done", int'({halt, done}), 0);
    chk(halt_cnt == 513, "R9 halt length", halt_cnt, 513);
    chk(done_cnt == 1, "R7 done pulse count", done_cnt, 1);
    repeat (4) begin
      @(negedge clk);
      chk(!halt && !mem_rd, "R8 no restart", int'({halt, mem_rd}), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rd_cnt = 0; wr_cnt = 0; halt_cnt = 0; done_cnt = 0;
    repeat (3) @(negedge clk);
    chk({halt, mem_rd, oam_we, done} == 4'b0, "R1 reset state",
        int'({halt, mem_rd, oam_we, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({halt, mem_rd, oam_we, done} == 4'b0, "R1 after release",
        int'({halt, mem_rd, oam_we, done}), 0);

    bus_write(16'h4015, 8'h12);
    bus_write(16'h2014, 8'h34);
    bus_write(16'h0014, 8'h56);
    repeat (3) begin
      @(negedge clk);
      chk(!halt && !mem_rd, "R2 other address ignored", int'({halt, mem_rd}), 0);
    end

    run_dma(8'h00, 1'b0);
    run_dma(8'hFF, 1'b0);
    run_dma(8'h02, 1'b1);
    for (int i = 0; i < 10; i++) run_dma(8'($urandom), bit'($urandom % 2));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule